// File: doc/BRIEF.md
# Round-Robin ADC Scan Sequencer

This block keeps one shared analog-to-digital converter busy across a small set of input slots. Each slot owns a channel-configuration byte held in a parameter table. The sequencer puts that byte on the converter's configuration port and waits a fixed number of clock cycles so the input can settle. It then pulses a start strobe. When a service tick arrives and the converter is no longer busy, the sequencer stores the finished conversion into a result bank entry chosen by the slot that was converting. It then moves to the next slot, loads that slot's configuration and starts the settle wait again.

A conversion is launched straight out of reset without any tick, so the first service already finds valid data. The visiting order runs upward or downward with wrap-around. A mask input removes slots from the rotation. Software-side logic reads stored results through a combinational read port that returns each 10-bit result split into a low byte and a high part.

Top module: `adc_scan_sequencer`

## Requirements
- R1: While reset is held, and right after it, `cur_slot` is 0, `adc_chan_cfg` equals table entry 0, `adc_start` is low and every result entry reads as zero.
- R2: Without any tick, `adc_start` pulses for the first time exactly `SETTLE_CYC` rising edges after reset is released.
- R3: Every `adc_start` pulse is one cycle wide. When a tick is serviced at once (converter idle), `adc_start` rises `SETTLE_CYC`+1 rising edges after the edge that samples the tick, counting that edge.
- R4: A service writes `adc_data` into the entry indexed by the slot that was converting, and only when `adc_busy` is low. The read port returns bits 7:0 of entry `rd_slot` on `rd_lo` and bits 9:8 on `rd_hi`.
- R5: With `skip_mask` all zero and `scan_down` low, successive services visit slots in the order 0,1,2,3,0, and so on.
- R6: With `scan_down` high, the next slot is the previous index, wrapping from 0 to `NUM_SLOTS`-1.
- R7: A slot whose `skip_mask` bit (bit i for slot i) is 1 is never chosen as the next slot, and its stored result keeps its value.
- R8: A `skip_mask` with every bit set is treated as if no bit were set.
- R9: A tick that arrives while a conversion is running is held and serviced once `adc_busy` falls. Several ticks before one service produce only one service.
- R10: `adc_chan_cfg` always equals byte `cur_slot` of `SLOT_CFG` (slot k occupies bits k*8+7 down to k*8).
- R11: Between two services at most one `adc_start` pulse occurs, and the slot index changes only on a service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Service request pulse |
| skip_mask | input | NUM_SLOTS | Bit i set removes slot i from the rotation |
| scan_down | input | 1 | 1: descending slot order, 0: ascending |
| adc_busy | input | 1 | Converter busy flag |
| adc_data | input | DATA_W | Finished conversion value |
| rd_slot | input | SLOT_W | Result bank read index |
| adc_chan_cfg | output | CFG_W | Channel configuration byte of the converting slot |
| adc_start | output | 1 | One-cycle conversion start strobe |
| cur_slot | output | SLOT_W | Slot whose conversion is in flight |
| rd_lo | output | LOW_W | Low byte of the addressed result |
| rd_hi | output | DATA_W-LOW_W | High bits of the addressed result |

## Verification
The bench builds the block with four slots and a settle count of five cycles, against a registered converter model whose conversion length it can change. The slot count is small and the settle wait is short, so every one of the sixteen skip masks can be swept in both directions with several services each. That sweep covers wrap-around, single-slot rotation and the all-ones mask. A separate run stretches a conversion so that several ticks fall inside it, which exercises the held-tick path.

// File: rtl/adc_scan_pkg.sv
// Package: shared types and helpers for the ADC scan sequencer.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package adc_scan_pkg;

    // Sequencer phases: wait out settling, pulse start, wait for service.
    typedef enum logic [1:0] {
        SQ_SETTLE = 2'd0,
        SQ_LAUNCH = 2'd1,
        SQ_AWAIT  = 2'd2
    } seq_state_e;

    // Index width for a slot count, never below one bit.
    function automatic int slot_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/scan_slot_picker.sv
// Module: scan_slot_picker
// Chooses the slot that follows cur_slot, stepping up or down with
// wrap-around and passing over masked slots. A fully set mask counts as
// empty. If only the current slot is unmasked, it is picked again.
// Assumes: cur_slot < NUM_SLOTS.
module scan_slot_picker #(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2
) (
    input  logic [SLOT_W-1:0]    cur_slot,
    input  logic [NUM_SLOTS-1:0] skip_mask,
    input  logic                 scan_down,
    output logic [SLOT_W-1:0]    next_slot
);

    logic [NUM_SLOTS-1:0] eff_mask;
    logic                 found;
    int                   cand;

    // Search candidates in visiting order; the first unmasked one wins.
    always_comb begin
        eff_mask  = (&skip_mask) ? '0 : skip_mask;
        next_slot = cur_slot;
        found     = 1'b0;
        cand      = 0;
        for (int step = 1; step <= NUM_SLOTS; step++) begin
            if (scan_down) begin
                cand = (int'(cur_slot) + NUM_SLOTS - step) % NUM_SLOTS;
            end else begin
                cand = (int'(cur_slot) + step) % NUM_SLOTS;
            end
            if (!found && !eff_mask[cand[SLOT_W-1:0]]) begin
                next_slot = cand[SLOT_W-1:0];
                found     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/scan_settle_timer.sv
// Module: scan_settle_timer
// Counts the cycles while run is high and flags the final cycle of a
// LIMIT-cycle window. The count wraps to zero on that cycle; clear forces
// it back to zero.
// Assumes: LIMIT >= 1.
module scan_settle_timer #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic done
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    assign done = run && (cnt_q == CNT_W'(LIMIT - 1));

    // Advance the settle count while running, wrapping at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= done ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/scan_result_bank.sv
// Module: scan_result_bank
// Holds one conversion result per slot. A single write port is indexed by
// slot; a combinational read port is indexed by rd_slot. Reset clears every
// entry. An index at or beyond NUM_SLOTS reads as zero.
// Assumes: at most one write per cycle.
module scan_result_bank #(
    parameter int NUM_SLOTS = 4,
    parameter int DATA_W    = 10,
    parameter int SLOT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] entry_q [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_entry
        // Capture the write data when this entry is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[g] <= '0;
            end else if (wr_en && (wr_slot == SLOT_W'(g))) begin
                entry_q[g] <= wr_data;
            end
        end
    end

    // Select the addressed entry for the read port.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (rd_slot == SLOT_W'(k)) begin
                rd_data = entry_q[k];
            end
        end
    end

endmodule

// File: rtl/adc_scan_sequencer.sv
// Module: adc_scan_sequencer (top)
// Steps a shared converter through a table of slot configurations. Reset
// loads slot 0 and launches a conversion after the settle wait. Each later
// service stores the converter result for the converting slot, picks the
// next slot, loads its configuration, settles and launches again. Ticks
// are remembered until the converter is idle.
// Assumes: the converter raises adc_busy in the cycle after it samples
// adc_start and holds adc_data valid once adc_busy is low.
module adc_scan_sequencer #(
    parameter int                           NUM_SLOTS  = 4,
    parameter int                           DATA_W     = 10,
    parameter int                           LOW_W      = 8,
    parameter int                           CFG_W      = 8,
    parameter int                           SETTLE_CYC = 20,
    parameter logic [NUM_SLOTS*CFG_W-1:0]   SLOT_CFG   = 32'h47_35_23_11,
    localparam int                          SLOT_W     = adc_scan_pkg::slot_bits(NUM_SLOTS),
    localparam int                          HIGH_W     = DATA_W - LOW_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [NUM_SLOTS-1:0] skip_mask,
    input  logic                 scan_down,
    input  logic                 adc_busy,
    input  logic [DATA_W-1:0]    adc_data,
    input  logic [SLOT_W-1:0]    rd_slot,
    output logic [CFG_W-1:0]     adc_chan_cfg,
    output logic                 adc_start,
    output logic [SLOT_W-1:0]    cur_slot,
    output logic [LOW_W-1:0]     rd_lo,
    output logic [HIGH_W-1:0]    rd_hi
);

    import adc_scan_pkg::*;

    seq_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] slot_nxt;
    logic [CFG_W-1:0]  cfg_q;
    logic [CFG_W-1:0]  cfg_nxt;
    logic              pend_q;
    logic              svc_w;
    logic              settle_done;
    logic [DATA_W-1:0] rd_word;

    // A service needs a request (new or held) and an idle converter.
    assign svc_w = (state_q == SQ_AWAIT) && (pend_q || tick) && !adc_busy;

    scan_slot_picker #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) picker_i (
        .cur_slot  (slot_q),
        .skip_mask (skip_mask),
        .scan_down (scan_down),
        .next_slot (slot_nxt)
    );

    scan_settle_timer #(
        .LIMIT (SETTLE_CYC)
    ) settle_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (svc_w),
        .run   (state_q == SQ_SETTLE),
        .done  (settle_done)
    );

    scan_result_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .DATA_W    (DATA_W),
        .SLOT_W    (SLOT_W)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (svc_w),
        .wr_slot (slot_q),
        .wr_data (adc_data),
        .rd_slot (rd_slot),
        .rd_data (rd_word)
    );

    // Look up the configuration byte of the slot chosen next.
    always_comb begin
        cfg_nxt = SLOT_CFG[int'(slot_nxt)*CFG_W +: CFG_W];
    end

    // Phase sequencing: settle, one launch cycle, then wait for service.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SQ_SETTLE: if (settle_done) state_d = SQ_LAUNCH;
            SQ_LAUNCH: state_d = SQ_AWAIT;
            SQ_AWAIT:  if (svc_w) state_d = SQ_SETTLE;
            default:   state_d = SQ_SETTLE;
        endcase
    end

    // Phase register; reset enters the settle wait for the first launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_SETTLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Slot index and its configuration move together on a service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            cfg_q  <= SLOT_CFG[CFG_W-1:0];
        end else if (svc_w) begin
            slot_q <= slot_nxt;
            cfg_q  <= cfg_nxt;
        end
    end

    // Remember a tick until a service consumes it; repeats merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (svc_w) begin
            pend_q <= 1'b0;
        end else if (tick) begin
            pend_q <= 1'b1;
        end
    end

    assign adc_chan_cfg = cfg_q;
    assign adc_start    = (state_q == SQ_LAUNCH);
    assign cur_slot     = slot_q;
    assign rd_lo        = rd_word[LOW_W-1:0];
    assign rd_hi        = rd_word[DATA_W-1:LOW_W];

endmodule

// File: rtl/adc_scan_sequencer_chk.sv
// Module: adc_scan_sequencer_chk
// Assertion checker bound into adc_scan_sequencer. It watches the port
// timing plus the internal service strobe.
// Assumes: same parameters as the bound instance.
module adc_scan_sequencer_chk #(
    parameter int                         NUM_SLOTS  = 4,
    parameter int                         CFG_W      = 8,
    parameter int                         SETTLE_CYC = 20,
    parameter logic [NUM_SLOTS*CFG_W-1:0] SLOT_CFG   = '0,
    parameter int                         SLOT_W     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SLOTS-1:0] skip_mask,
    input logic                 adc_busy,
    input logic                 adc_start,
    input logic [CFG_W-1:0]     adc_chan_cfg,
    input logic [SLOT_W-1:0]    cur_slot,
    input logic                 svc
);

    localparam int GAP_W = $clog2(SETTLE_CYC + 2);

    logic [GAP_W-1:0]     gap_q;
    logic                 armed_q;
    logic [NUM_SLOTS-1:0] mask_q;

    // Cycles since the last service or reset, saturating past the window.
    always_ff @(posedge clk) begin
        if (!rst_n || svc) begin
            gap_q <= '0;
        end else if (gap_q != GAP_W'(SETTLE_CYC + 1)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Tracks whether a launch is still owed for the latest service.
    always_ff @(posedge clk) begin
        if (!rst_n || svc) begin
            armed_q <= 1'b1;
        end else if (adc_start) begin
            armed_q <= 1'b0;
        end
    end

    // Mask as seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= skip_mask;
        end
    end

    p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    p_settle_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (gap_q == GAP_W'(SETTLE_CYC)));

    p_one_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> armed_q);

    p_service_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        svc |-> !adc_busy);

    p_slot_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !svc |=> $stable(cur_slot));

    p_skip_honoured_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (svc && !(&skip_mask)) |=> !mask_q[cur_slot]);

    p_cfg_table_r10: assert property (@(posedge clk) disable iff (!rst_n)
        adc_chan_cfg == SLOT_CFG[int'(cur_slot)*CFG_W +: CFG_W]);

endmodule

bind adc_scan_sequencer adc_scan_sequencer_chk #(
    .NUM_SLOTS  (NUM_SLOTS),
    .CFG_W      (CFG_W),
    .SETTLE_CYC (SETTLE_CYC),
    .SLOT_CFG   (SLOT_CFG),
    .SLOT_W     (SLOT_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .skip_mask    (skip_mask),
    .adc_busy     (adc_busy),
    .adc_start    (adc_start),
    .adc_chan_cfg (adc_chan_cfg),
    .cur_slot     (cur_slot),
    .svc          (svc_w)
);

// File: tb/adc_scan_sequencer_tb_top.sv
// Bench: sweeps every skip mask in both directions and stretches one
// conversion to test held ticks. Expected values come from the
// requirements only.
module adc_scan_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int S          = 5;
    localparam logic [31:0] TB_CFG = 32'hC4_9A_5E_17;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic [3:0] skip_mask;
    logic       scan_down;
    logic       adc_busy;
    logic [9:0] adc_data;
    logic [1:0] rd_slot;
    logic [7:0] adc_chan_cfg;
    logic       adc_start;
    logic [1:0] cur_slot;
    logic [7:0] rd_lo;
    logic [1:0] rd_hi;

    int n_checks = 0;
    int n_fail   = 0;
    int conv_len = 3;
    int exp_slot;
    int conv_n;
    int exp_res [N];
    int adc_left;
    int adc_serial;
    logic [7:0] adc_cap;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_scan_sequencer #(
        .NUM_SLOTS  (N),
        .DATA_W     (10),
        .LOW_W      (8),
        .CFG_W      (8),
        .SETTLE_CYC (S),
        .SLOT_CFG   (TB_CFG)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .skip_mask    (skip_mask),
        .scan_down    (scan_down),
        .adc_busy     (adc_busy),
        .adc_data     (adc_data),
        .rd_slot      (rd_slot),
        .adc_chan_cfg (adc_chan_cfg),
        .adc_start    (adc_start),
        .cur_slot     (cur_slot),
        .rd_lo        (rd_lo),
        .rd_hi        (rd_hi)
    );

    function automatic int cfg_of(input int s);
        return int'(TB_CFG[s*8 +: 8]);
    endfunction

    function automatic int conv_val(input int cfg, input int n);
        return (cfg * 37 + n * 101 + 5) % 1024;
    endfunction

    function automatic int next_of(input int cur, input int m, input bit dn);
        int em;
        em = (m == 15) ? 0 : m;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = dn ? (cur + N - k) % N : (cur + k) % N;
            if (((em >> c) & 1) == 0) return c;
        end
        return cur;
    endfunction

    // Converter model: busy the cycle after start, result when it ends.
    always @(posedge clk) begin
        if (!rst_n) begin
            adc_busy   <= 1'b0;
            adc_data   <= '0;
            adc_left   <= 0;
            adc_serial <= 0;
            adc_cap    <= '0;
        end else if (adc_start) begin
            adc_busy <= 1'b1;
            adc_left <= conv_len;
            adc_cap  <= adc_chan_cfg;
        end else if (adc_busy) begin
            if (adc_left <= 1) begin
                adc_busy   <= 1'b0;
                adc_data   <= 10'(conv_val(int'(adc_cap), adc_serial));
                adc_serial <= adc_serial + 1;
            end else begin
                adc_left <= adc_left - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_bank(input string tag);
        for (int s = 0; s < N; s++) begin
            int got;
            rd_slot = 2'(s);
            #1;
            got = int'({rd_hi, rd_lo});
            chk(got == exp_res[s], tag, got, exp_res[s]);
        end
    endtask

    task automatic record_service();
        exp_res[exp_slot] = conv_val(cfg_of(exp_slot), conv_n);
        conv_n++;
        exp_slot = next_of(exp_slot, int'(skip_mask), scan_down);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (adc_busy) begin
            chk(!adc_start, "R11 no extra start", int'(adc_start), 0);
            @(negedge clk);
        end
    endtask

    // Tick with the converter idle; measure the settle gap, then check.
    task automatic service(input string order_tag);
        int n;
        n = 0;
        tick = 1'b1;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            tick = 1'b0;
        end while (!adc_start && n < 200);
        chk(n == S + 1, "R3 settle gap", n, S + 1);
        record_service();
        chk(int'(cur_slot) == exp_slot, order_tag, int'(cur_slot), exp_slot);
        chk(int'(adc_chan_cfg) == cfg_of(exp_slot), "R10 cfg", int'(adc_chan_cfg), cfg_of(exp_slot));
        check_bank("R4 stored result");
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int n;
        int starts;
        rst_n = 1'b0; tick = 1'b0; skip_mask = '0; scan_down = 1'b0; rd_slot = '0;
        for (int s = 0; s < N; s++) exp_res[s] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(cur_slot == 2'd0, "R1 slot", int'(cur_slot), 0);
        chk(int'(adc_chan_cfg) == cfg_of(0), "R1 cfg", int'(adc_chan_cfg), cfg_of(0));
        chk(!adc_start, "R1 start", int'(adc_start), 0);
        check_bank("R1 cleared");
        rst_n = 1'b1;
        // R2: first launch without a tick
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!adc_start && n < 100);
        chk(n == S, "R2 first launch", n, S);
        chk(cur_slot == 2'd0, "R1 slot after release", int'(cur_slot), 0);
        wait_idle();
        exp_slot = 0;
        conv_n   = 0;

        // Sweep: every mask, both directions
        for (int dir = 0; dir < 2; dir++) begin
            for (int m = 0; m < 16; m++) begin
                string tag;
                skip_mask = 4'(m);
                scan_down = dir[0];
                if (m == 15)     tag = "R8 full mask";
                else if (m != 0) tag = "R7 skip";
                else if (dir == 1) tag = "R6 descending";
                else             tag = "R5 ascending";
                for (int k = 0; k < 6; k++) service(tag);
            end
        end

        // R9: ticks during a long conversion collapse into one service
        skip_mask = '0;
        scan_down = 1'b0;
        conv_len  = 20;
        n = 0;
        tick = 1'b1;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            tick = 1'b0;
        end while (!adc_start && n < 200);
        record_service();
        starts = 0;
        for (int c = 0; c < 50; c++) begin
            @(negedge clk);
            if (c == 2 || c == 5 || c == 8) begin
                chk(adc_busy, "R9 busy during tick", int'(adc_busy), 1);
                tick = 1'b1;
            end else begin
                tick = 1'b0;
            end
            if (adc_start) starts++;
        end
        tick = 1'b0;
        chk(starts == 1, "R9 held tick starts", starts, 1);
        record_service();
        chk(int'(cur_slot) == exp_slot, "R9 slot", int'(cur_slot), exp_slot);
        check_bank("R9 stored result");
        conv_len = 3;
        wait_idle();
        service("R5 ascending after hold");

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule